// File: doc/BRIEF.md
# FIFO Flag Offset Programming Controller

This block fills the four threshold registers that a pair of opposite-direction FIFOs compare against to raise their almost-empty and almost-full flags. There is one almost-full threshold for each FIFO's write side and one almost-empty threshold for each FIFO's read side. The load method is fixed once per reset. The block samples its select pins when reset ends and then picks one of three paths: a built-in constant, the first four words written on the write port, or a bit stream clocked in on a serial data and enable pin pair. The serial pins share their wires with the select pins.

The block holds the write-side "input ready" outputs of both FIFOs low until their thresholds are settled. It also keeps parallel programming words from reaching FIFO memory. When programming ends, it raises a one-cycle completion pulse. The first FIFO's ready output and the write strobe live in the write clock domain. The second FIFO's ready output crosses into that FIFO's own write clock through a synchronizer chain.

Top module: `ofs_prog_ctrl`

## Requirements
- R1: While `rst_n` is low, all four offset outputs read 64, `ready_a_o`, `ready_c_o` and `prog_done_o` are low, and `fifo_wr_o` is low.
- R2: The select pins are sampled only on the first rising `clk_a` edge with `rst_n` high (the capture edge). Afterwards, changes on `prog_mode_i`, `sel1_sen_n_i`, `sel0_sdat_i` and `wr_data_i` have no effect on the offsets until the next reset.
- R3: At the capture edge, `prog_mode_i`=1 selects a preset according to (`sel1_sen_n_i`,`sel0_sdat_i`): (1,1) gives 64, (1,0) gives 16 and (0,1) gives 8. All four offsets take that value at the capture edge, and `ready_a_o` is high after it.
- R4: At the capture edge, `prog_mode_i`=0 with (`sel1_sen_n_i`,`sel0_sdat_i`) other than (1,0) is reserved. All four offsets stay at 64, and programming completes at that edge as for a preset.
- R5: `prog_mode_i`=1 with both selects at 0 selects parallel mode. `ready_a_o` is high after the capture edge. The next four edges with `wr_en_i` high load `wr_data_i` (bit OFS_W-1 is the MSB) into the almost-full threshold for the first FIFO's writer, then the almost-empty threshold for the first FIFO's reader, then the almost-full threshold for the second FIFO's writer, then the almost-empty threshold for the second FIFO's reader.
- R6: `fifo_wr_o` equals `wr_en_i` once programming is complete, and is 0 before that, including during parallel-mode writes.
- R7: `prog_mode_i`=0, `sel0_sdat_i`=0, `sel1_sen_n_i`=1 selects serial mode. Each rising `clk_a` edge with `sel1_sen_n_i` low takes one bit from `sel0_sdat_i`, and edges with it high take nothing. The 4*OFS_W bits fill the registers in the R5 order, MSB first, so the last bit is the LSB of the second FIFO's read-side almost-empty threshold.
- R8: In serial mode, `ready_a_o` stays low and the offsets stay at 64 until the edge that takes the last bit. At that edge, all four offsets update and `ready_a_o` goes high.
- R9: After programming completes, serial bits, write-port words and select pins leave the offsets unchanged.
- R10: `prog_done_o` is high for exactly one `clk_a` cycle, following the edge at which programming completes (capture edge for preset or reserved, fourth write for parallel, last bit for serial).
- R11: `ready_c_o` is low until programming completes. It rises on the SYNC_STAGES-th `clk_c` edge after the completing edge (counted with `clk_c` in phase with `clk_a`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock of the first FIFO; all programming happens on it |
| clk_c | input | 1 | Write-side clock of the second FIFO |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk_a` |
| prog_mode_i | input | 1 | Program-mode select, sampled at the capture edge |
| sel1_sen_n_i | input | 1 | Select bit 1 at capture; active-low serial enable afterwards |
| sel0_sdat_i | input | 1 | Select bit 0 at capture; serial data afterwards |
| wr_en_i | input | 1 | Write strobe of the first FIFO's write port |
| wr_data_i | input | OFS_W | Low bits of the write data word, used as parallel offset values |
| ofs_af_a_o | output | OFS_W | Almost-full threshold, first FIFO writer side |
| ofs_ae_b_o | output | OFS_W | Almost-empty threshold, first FIFO reader side |
| ofs_af_c_o | output | OFS_W | Almost-full threshold, second FIFO writer side |
| ofs_ae_a_o | output | OFS_W | Almost-empty threshold, second FIFO reader side |
| ready_a_o | output | 1 | Input-ready of the first FIFO (clk_a domain) |
| ready_c_o | output | 1 | Input-ready of the second FIFO (clk_c domain) |
| prog_done_o | output | 1 | One-cycle pulse when programming completes |
| fifo_wr_o | output | 1 | Write strobe passed on to FIFO memory |

## Verification
The bench builds the block with OFS_W=8 and SYNC_STAGES=2, and ties `clk_c` to `clk_a`. With these values a full serial load is 32 bits, and the ready crossing delay is a fixed two-edge count that can be sampled exactly. All eight select-pin combinations are swept at reset release, so every preset, reserved and programming path is reached. Parallel and serial loads run with several value sets, including the legal extremes 1 and 252. The serial stream is gapped by idle enable cycles, and stray bits and writes are applied after completion.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;
  localparam int unsigned NUM_OFS    = 4;
  localparam int unsigned PRESET_HI  = 64;
  localparam int unsigned PRESET_MID = 16;
  localparam int unsigned PRESET_LO  = 8;

  // Register order used by both programming paths.
  localparam int unsigned IDX_AF_A = 0;
  localparam int unsigned IDX_AE_B = 1;
  localparam int unsigned IDX_AF_C = 2;
  localparam int unsigned IDX_AE_A = 3;

  typedef enum logic [1:0] {
    ST_CAPTURE,
    ST_PARALLEL,
    ST_SERIAL,
    ST_RUN
  } prog_state_e;

  typedef enum logic [1:0] {
    LD_PRESET,
    LD_PARALLEL,
    LD_SERIAL
  } load_kind_e;
endpackage

// File: rtl/ofs_mode_decode.sv
module ofs_mode_decode
  import ofs_prog_pkg::*;
#(
  parameter int unsigned OFS_W = 8
) (
  input  logic             prog_mode_i,
  input  logic             sel1_i,
  input  logic             sel0_i,
  output load_kind_e       kind_o,
  output logic [OFS_W-1:0] preset_o
);
  always_comb begin
    kind_o   = LD_PRESET;
    preset_o = OFS_W'(PRESET_HI);
    unique case ({prog_mode_i, sel1_i, sel0_i})
      3'b111:  preset_o = OFS_W'(PRESET_HI);
      3'b110:  preset_o = OFS_W'(PRESET_MID);
      3'b101:  preset_o = OFS_W'(PRESET_LO);
      3'b100:  kind_o   = LD_PARALLEL;
      3'b010:  kind_o   = LD_SERIAL;
      default: preset_o = OFS_W'(PRESET_HI); // reserved: defined default
    endcase
  end
endmodule

// File: rtl/ofs_serial_loader.sv
module ofs_serial_loader #(
  parameter int unsigned OFS_W = 8,
  parameter int unsigned NUM   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active_i,
  input  logic                 bit_en_i,
  input  logic                 bit_i,
  output logic                 last_o,
  output logic [NUM*OFS_W-1:0] word_o
);
  localparam int unsigned TOTAL = NUM * OFS_W;
  localparam int unsigned CNT_W = $clog2(TOTAL);

  logic [TOTAL-2:0] shift_q, shift_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             take;

  assign take   = active_i && bit_en_i;
  assign last_o = take && (cnt_q == CNT_W'(TOTAL - 1));
  assign word_o = {shift_q, bit_i};

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    if (take) begin
      shift_d = {shift_q[TOTAL-3:0], bit_i};
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
    end
  end

  // R7: one bit counted per enabled edge, none otherwise
  p_bit_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !last_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cnt_q));
endmodule

// File: rtl/ofs_ready_sync.sv
module ofs_ready_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q, chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = d_i;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ofs_prog_ctrl.sv
module ofs_prog_ctrl
  import ofs_prog_pkg::*;
#(
  parameter int unsigned OFS_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_a,
  input  logic             clk_c,
  input  logic             rst_n,
  input  logic             prog_mode_i,
  input  logic             sel1_sen_n_i,
  input  logic             sel0_sdat_i,
  input  logic             wr_en_i,
  input  logic [OFS_W-1:0] wr_data_i,
  output logic [OFS_W-1:0] ofs_af_a_o,
  output logic [OFS_W-1:0] ofs_ae_b_o,
  output logic [OFS_W-1:0] ofs_af_c_o,
  output logic [OFS_W-1:0] ofs_ae_a_o,
  output logic             ready_a_o,
  output logic             ready_c_o,
  output logic             prog_done_o,
  output logic             fifo_wr_o
);
  localparam int unsigned IDX_W = $clog2(NUM_OFS);
  localparam int unsigned SER_W = NUM_OFS * OFS_W;

  prog_state_e                      state_q, state_d;
  logic [NUM_OFS-1:0][OFS_W-1:0]    ofs_q, ofs_d;
  logic [IDX_W-1:0]                 idx_q, idx_d;
  logic                             ready_a_q, ready_a_d;
  logic                             fin_q, fin_d;
  logic                             done_q, done_d;
  load_kind_e                       kind;
  logic [OFS_W-1:0]                 preset;
  logic                             ser_last;
  logic [SER_W-1:0]                 ser_word;

  ofs_mode_decode #(.OFS_W(OFS_W)) i_decode (
    .prog_mode_i (prog_mode_i),
    .sel1_i      (sel1_sen_n_i),
    .sel0_i      (sel0_sdat_i),
    .kind_o      (kind),
    .preset_o    (preset)
  );

  ofs_serial_loader #(.OFS_W(OFS_W), .NUM(NUM_OFS)) i_serial (
    .clk      (clk_a),
    .rst_n    (rst_n),
    .active_i (state_q == ST_SERIAL),
    .bit_en_i (!sel1_sen_n_i),
    .bit_i    (sel0_sdat_i),
    .last_o   (ser_last),
    .word_o   (ser_word)
  );

  ofs_ready_sync #(.STAGES(SYNC_STAGES)) i_sync_c (
    .clk   (clk_c),
    .rst_n (rst_n),
    .d_i   (fin_q),
    .q_o   (ready_c_o)
  );

  always_comb begin
    state_d   = state_q;
    ofs_d     = ofs_q;
    idx_d     = idx_q;
    ready_a_d = ready_a_q;
    fin_d     = fin_q;
    done_d    = 1'b0;
    unique case (state_q)
      ST_CAPTURE: begin
        unique case (kind)
          LD_PARALLEL: begin
            state_d   = ST_PARALLEL;
            ready_a_d = 1'b1;
          end
          LD_SERIAL: state_d = ST_SERIAL;
          default: begin
            for (int i = 0; i < NUM_OFS; i++) ofs_d[i] = preset;
            state_d   = ST_RUN;
            ready_a_d = 1'b1;
            fin_d     = 1'b1;
            done_d    = 1'b1;
          end
        endcase
      end
      ST_PARALLEL: begin
        if (wr_en_i) begin
          ofs_d[idx_q] = wr_data_i;
          idx_d        = idx_q + 1'b1;
          if (idx_q == IDX_W'(NUM_OFS - 1)) begin
            state_d = ST_RUN;
            fin_d   = 1'b1;
            done_d  = 1'b1;
          end
        end
      end
      ST_SERIAL: begin
        if (ser_last) begin
          for (int i = 0; i < NUM_OFS; i++)
            ofs_d[i] = ser_word[(NUM_OFS-1-i)*OFS_W +: OFS_W];
          state_d   = ST_RUN;
          ready_a_d = 1'b1;
          fin_d     = 1'b1;
          done_d    = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_CAPTURE;
      for (int i = 0; i < NUM_OFS; i++) ofs_q[i] <= OFS_W'(PRESET_HI);
      idx_q     <= '0;
      ready_a_q <= 1'b0;
      fin_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      ofs_q     <= ofs_d;
      idx_q     <= idx_d;
      ready_a_q <= ready_a_d;
      fin_q     <= fin_d;
      done_q    <= done_d;
    end
  end

  assign ofs_af_a_o  = ofs_q[IDX_AF_A];
  assign ofs_ae_b_o  = ofs_q[IDX_AE_B];
  assign ofs_af_c_o  = ofs_q[IDX_AF_C];
  assign ofs_ae_a_o  = ofs_q[IDX_AE_A];
  assign ready_a_o   = ready_a_q;
  assign prog_done_o = done_q;
  assign fifo_wr_o   = wr_en_i && fin_q;

  p_done_single_r10: assert property (@(posedge clk_a) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_after_fin_r10: assert property (@(posedge clk_a) disable iff (!rst_n)
    done_q |-> (fin_q && ready_a_q));
  p_serial_not_ready_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
    (state_q == ST_SERIAL) |-> !ready_a_q);
  p_frozen_after_run_r9: assert property (@(posedge clk_a) disable iff (!rst_n)
    (state_q == ST_RUN) |=> $stable(ofs_q));
  p_no_mem_write_par_r6: assert property (@(posedge clk_a) disable iff (!rst_n)
    (state_q == ST_PARALLEL) |-> !fifo_wr_o);
endmodule

// File: tb/test_ofs_prog_ctrl.sv
`timescale 1ns/1ps
module test_ofs_prog_ctrl;
  localparam int unsigned OFS_W = 8;
  localparam int unsigned SYNC  = 2;
  localparam int unsigned NBITS = 4 * OFS_W;
  localparam logic [31:0] ALL64 = 32'h40404040;

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic clk_c;
  assign clk_c = clk;

  logic rst_n = 1'b0, pm = 1'b0, s1 = 1'b1, s0 = 1'b0, wr_en = 1'b0;
  logic [OFS_W-1:0] wr_data = '0;
  logic [OFS_W-1:0] af_a, ae_b, af_c, ae_a;
  logic rdy_a, rdy_c, done, fwr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  ofs_prog_ctrl #(.OFS_W(OFS_W), .SYNC_STAGES(SYNC)) i_ofs_prog_ctrl (
    .clk_a(clk), .clk_c(clk_c), .rst_n(rst_n),
    .prog_mode_i(pm), .sel1_sen_n_i(s1), .sel0_sdat_i(s0),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ofs_af_a_o(af_a), .ofs_ae_b_o(ae_b), .ofs_af_c_o(af_c), .ofs_ae_a_o(ae_a),
    .ready_a_o(rdy_a), .ready_c_o(rdy_c), .prog_done_o(done), .fifo_wr_o(fwr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_ofs(input string req, input logic [31:0] exp);
    chk(req, {af_a, ae_b, af_c, ae_a}, exp);
  endtask

  // Hold reset, set select pins, release; return at the negedge after the capture edge.
  task automatic start(input logic p, input logic a, input logic b);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; pm = p; s1 = a; s0 = b;
    @(negedge clk);
    @(negedge clk);
    chk_ofs("R1 offsets in reset", ALL64);
    chk("R1 flags in reset", {rdy_a, rdy_c, done, fwr}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // After the completing edge: done pulse then ready_c timing.
  task automatic check_completion(input string tag);
    chk({tag, " R10 done high"}, done, 1'b1);
    chk({tag, " R8 ready_a high"}, rdy_a, 1'b1);
    chk({tag, " R11 ready_c low"}, rdy_c, 1'b0);
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, done, 1'b0);
    chk({tag, " R11 ready_c still low"}, rdy_c, 1'b0);
    @(negedge clk);
    chk({tag, " R11 ready_c high"}, rdy_c, 1'b1);
  endtask

  task automatic disturb(input logic [31:0] exp);
    for (int k = 0; k < 4; k++) begin
      pm = ~pm; s1 = k[0]; s0 = ~k[1]; wr_en = 1'b1; wr_data = OFS_W'(k * 37 + 3);
      #1 chk("R6 strobe passes after completion", fwr, 1'b1);
      @(negedge clk);
    end
    wr_en = 1'b0; s1 = 1'b1;
    chk_ofs("R9 R2 offsets frozen", exp);
    chk("R10 no second done", done, 1'b0);
  endtask

  task automatic par_load(input logic [31:0] vals);
    logic [31:0] exp;
    exp = ALL64;
    start(1'b1, 1'b0, 1'b0);
    chk("R5 ready_a high in parallel", rdy_a, 1'b1);
    s1 = 1'b1; s0 = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wr_en = 1'b1; wr_data = vals[31-8*i -: 8];
      #1 chk("R6 programming write not stored", fwr, 1'b0);
      @(negedge clk);
      wr_en = 1'b0;
      exp[31-8*i -: 8] = vals[31-8*i -: 8];
      chk_ofs("R5 register order", exp);
      if (i < 3) begin
        chk("R10 no early done", done, 1'b0);
        chk("R11 ready_c low while loading", rdy_c, 1'b0);
        @(negedge clk);
      end
    end
    check_completion("parallel");
    disturb(vals);
  endtask

  task automatic ser_load(input logic [31:0] w);
    start(1'b0, 1'b1, 1'b0);
    chk("R8 ready_a low in serial", rdy_a, 1'b0);
    for (int i = 0; i < NBITS; i++) begin
      if (i % 5 == 2) begin
        s1 = 1'b1; s0 = ~w[NBITS-1-i]; wr_en = 1'b1;
        #1 chk("R6 no strobe in serial", fwr, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
      end
      s1 = 1'b0; s0 = w[NBITS-1-i];
      @(negedge clk);
      s1 = 1'b1;
      if (i < NBITS - 1) begin
        if (i % 7 == 0) begin
          chk("R8 ready_a low mid-stream", rdy_a, 1'b0);
          chk_ofs("R8 offsets held mid-stream", ALL64);
          chk("R10 no early done", done, 1'b0);
        end
      end
    end
    chk_ofs("R7 serial bit order", w);
    check_completion("serial");
    disturb(w);
  endtask

  initial begin
    // Sweep of every select combination at reset release.
    for (int c = 0; c < 8; c++) begin
      logic p, a, b;
      logic [7:0] pv;
      p = c[2]; a = c[1]; b = c[0];
      start(p, a, b);
      if (p && !a && !b) begin
        chk("R5 parallel selected", {rdy_a, done}, 2'b10);
      end else if (!p && a && !b) begin
        chk("R7 serial selected", {rdy_a, done}, 2'b00);
      end else begin
        pv = (p && a && !b) ? 8'd16 : (p && !a && b) ? 8'd8 : 8'd64;
        if (p) chk_ofs("R3 preset value", {4{pv}});
        else   chk_ofs("R4 reserved default", {4{pv}});
        check_completion(p ? "R3 preset" : "R4 reserved");
        disturb({4{pv}});
      end
    end
    par_load({8'd12, 8'd250, 8'd1, 8'd99});
    par_load({8'd252, 8'd128, 8'd3, 8'd64});
    ser_load({8'd200, 8'd1, 8'd252, 8'd77});
    ser_load(32'hA53C0FF0);
    ser_load({8'd1, 8'd1, 8'd1, 8'd1});
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule